// File: doc/BRIEF.md
# Serial Link Zero-Pattern Self-Test

This block provides both ends of a built-in self-test for a serial link. On the transmit side, a mux sits in front of the serializer. While the transmit test enable is high, it replaces the parallel input word with an all-zeroes word. On the receive side, a checker compares each recovered word against zero, but only after the receiver reports lock. It counts erroneous words in a saturating counter and drives a live pass flag.

A test follows a fixed order:
1. The receiver's test enable goes high.
2. The transmitter's test enable goes high.
3. The receiver's enable drops, and the held verdict is read on `pass_o`.
4. The transmitter returns to normal traffic.

After the receive enable falls, the error count and the pass flag keep the result of the run just completed. They hold it until the next run starts, on the next rising edge of the receive enable.

Top module: `link_selftest`

## Requirements
- R1: `tx_data_o` equals `tx_data_i` while `tx_bist_en_i` is low, and equals all zeroes while it is high. The mux is combinational, so the output changes in the same cycle as the enable.
- R2: A recovered word is compared only in a cycle where `rx_lock_i` is high. Nonzero words that arrive while lock is low add nothing to the count.
- R3: The receive check is active in a cycle where `rx_bist_en_i` is high and was also high in the previous cycle. In such a cycle, a compared word with one or more nonzero bits raises `err_cnt_o` by exactly one at the next clock edge. A word that is all zeroes raises it by nothing.
- R4: `pass_o` goes low in the cycle after the first erroneous word of a run. It stays low for the rest of that run.
- R5: While `rx_bist_en_i` is low, `err_cnt_o` and `pass_o` hold their values, whatever arrives on `rx_data_i` and `rx_lock_i`.
- R6: The first cycle in which `rx_bist_en_i` is high after being low is a start cycle. It sets `err_cnt_o` to 0 and `pass_o` to 1 at the next edge, and the word in that cycle is not compared.
- R7: `err_cnt_o` saturates at 255 and does not wrap.
- R8: While the check is active, a high-to-low transition of `rx_lock_i` counts as one error and drives `pass_o` low. Comparison then pauses until lock returns.
- R9: During and after reset, `err_cnt_o` is 0 and `pass_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_bist_en_i | input | 1 | Transmit test enable, selects the zero word |
| tx_data_i | input | 24 | Parallel data toward the serializer |
| tx_data_o | output | 24 | Word handed to the serializer |
| rx_bist_en_i | input | 1 | Receive test enable |
| rx_lock_i | input | 1 | Receiver lock indication |
| rx_data_i | input | 24 | Recovered word from the deserializer |
| pass_o | output | 1 | Live pass flag during a run, held verdict after it |
| err_cnt_o | output | 8 | Saturating count of erroneous words |

## Verification
The count and the pass flag are registered one stage behind the comparison. A wrong count, a missed lock drop, or a flag that fails to clear therefore shows at `err_cnt_o` or `pass_o` exactly one cycle after the offending word or enable edge. The bench samples there, and it keeps each check to a single word.

A walking-one sweep across every data bit shows whether any comparator bit is stuck. A run that drops the enable and then feeds bad words shows whether the hold logic leaks. A 300-word run shows whether the counter wraps instead of saturating.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
  localparam int unsigned ERR_CNT_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/bist_tx_mux.sv
module bist_tx_mux #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              bist_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = bist_en_i ? '0 : data_i;
  end
endmodule

// File: rtl/bist_rx_compare.sv
module bist_rx_compare #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              err_o
);
  logic lock_q;
  logic word_bad;
  logic lock_lost;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_i;
  end

  always_comb begin
    word_bad  = lock_i && (|data_i);
    lock_lost = lock_q && !lock_i;
    err_o     = active_i && (word_bad || lock_lost);
  end

  // unlocked cycle can only flag an error on the cycle of the lock drop
  p_unlocked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !$past(lock_i)) |-> !err_o);
endmodule

// File: rtl/bist_verdict.sv
module bist_verdict #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             err_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pass_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pass_q <= 1'b1;
    end else if (start_i) begin
      cnt_q  <= '0;
      pass_q <= 1'b1;
    end else if (active_i && err_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      pass_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign pass_o = pass_q;

  p_pass_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && active_i && !start_i) |=> !pass_q);
  p_start_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0) && pass_q);
  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !start_i) |=> cnt_q == CNT_MAX);
  p_pass_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(start_i));
endmodule

// File: rtl/link_selftest.sv
module link_selftest
  import link_bist_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = ERR_CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_bist_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_bist_en_i,
  input  logic              rx_lock_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic      bist_q;
  rx_phase_e phase;
  logic      start, active, err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bist_q <= 1'b0;
    else         bist_q <= rx_bist_en_i;
  end

  always_comb begin
    if (!rx_bist_en_i) phase = PH_IDLE;
    else if (!bist_q)  phase = PH_START;
    else               phase = PH_RUN;
    start  = (phase == PH_START);
    active = (phase == PH_RUN);
  end

  bist_tx_mux #(.DATA_W(DATA_W)) u_tx_mux (
    .bist_en_i (tx_bist_en_i),
    .data_i    (tx_data_i),
    .data_o    (tx_data_o)
  );

  bist_rx_compare #(.DATA_W(DATA_W)) u_rx_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .lock_i   (rx_lock_i),
    .data_i   (rx_data_i),
    .err_o    (err)
  );

  bist_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_i (active),
    .err_i    (err),
    .cnt_o    (err_cnt_o),
    .pass_o   (pass_o)
  );

  always_comb begin
    if (tx_bist_en_i) p_tx_zero_r1: assert (tx_data_o == '0);
  end

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_bist_en_i |=> $stable(err_cnt_o) && $stable(pass_o));
  p_lock_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_bist_en_i && $past(rx_bist_en_i) && $fell(rx_lock_i)) |=> !pass_o);
endmodule

// File: tb/sim_link_selftest.sv
module sim_link_selftest;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_bist = 1'b0;
  logic [W-1:0]  tx_data = '0;
  logic [W-1:0]  tx_out;
  logic          rx_bist = 1'b0;
  logic          lock = 1'b0;
  logic [W-1:0]  inj = '0;
  logic [W-1:0]  rx_data;
  logic          pass;
  logic [7:0]    cnt;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // transparent link model: serializer output with injected bit flips
  assign rx_data = tx_out ^ inj;

  link_selftest u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_bist_en_i(tx_bist), .tx_data_i(tx_data), .tx_data_o(tx_out),
    .rx_bist_en_i(rx_bist), .rx_lock_i(lock), .rx_data_i(rx_data),
    .pass_o(pass), .err_cnt_o(cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int ec, input int ep);
    check(cnt == ec[7:0], {req, " count"}, int'(cnt), ec);
    check(pass == ep[0], {req, " pass"}, int'(pass), ep);
  endtask

  // drive at a falling edge, sample at the next one
  task automatic word(input logic [W-1:0] e, input logic lk);
    inj  = e;
    lock = lk;
    @(negedge clk);
  endtask

  task automatic restart(input logic lk);
    rx_bist = 1'b0; word('0, lk);
    rx_bist = 1'b1; word('0, lk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk_state("R9 in reset", 0, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_state("R9 after reset", 0, 1);

    // R1: mux sweep
    for (int b = 0; b < W; b++) begin
      tx_data = (W'(1) << b) | W'(24'h5A0000 >> (b % 8));
      tx_bist = 1'b0; #1;
      check(tx_out == tx_data, "R1 pass-through", int'(tx_out), int'(tx_data));
      tx_bist = 1'b1; #1;
      check(tx_out == '0, "R1 zero word", int'(tx_out), 0);
    end
    tx_bist = 1'b0;
    @(negedge clk);

    // run 1: rx enters test, then tx
    lock = 1'b1;
    rx_bist = 1'b1; word(24'hFFFFFF, 1'b1);
    chk_state("R6 start cycle not compared", 0, 1);
    tx_bist = 1'b1; tx_data = 24'hA5A5A5;
    for (int i = 0; i < 10; i++) word('0, 1'b1);
    chk_state("R1 R3 clean run with live data ignored", 0, 1);
    for (int b = 0; b < W; b++) begin
      word(W'(1) << b, 1'b1);
      chk_state("R3 R4 walking one", b + 1, 0);
    end
    word(24'hFFFFFF, 1'b1);
    chk_state("R3 multi-bit word counts once", 25, 0);
    word('0, 1'b1);
    chk_state("R4 stays low after clean word", 25, 0);
    rx_bist = 1'b0;
    for (int i = 0; i < 4; i++) word(24'hFFFFFF, i[0]);
    chk_state("R5 verdict held", 25, 0);

    // run 2: lock handling
    restart(1'b0);
    chk_state("R6 restart clears", 0, 1);
    for (int i = 0; i < 5; i++) word(24'h00F00F, 1'b0);
    chk_state("R2 unlocked words ignored", 0, 1);
    for (int i = 0; i < 3; i++) word('0, 1'b1);
    chk_state("R2 locked clean words", 0, 1);
    word('0, 1'b0);
    chk_state("R8 lock drop counts one", 1, 0);
    for (int i = 0; i < 4; i++) word(24'h800001, 1'b0);
    chk_state("R8 paused while unlocked", 1, 0);
    word(24'h000100, 1'b1);
    chk_state("R8 resumes on relock", 2, 0);
    rx_bist = 1'b0; word(24'hFFFFFF, 1'b0);
    chk_state("R5 held after run 2", 2, 0);

    // sweep of error counts per run
    for (int k = 0; k < 5; k++) begin
      restart(1'b1);
      for (int i = 0; i < 8; i++)
        word((i % 2 == 1 && i / 2 < k) ? (W'(3) << i) : '0, 1'b1);
      chk_state("R3 k errors in run", k, (k == 0) ? 1 : 0);
      rx_bist = 1'b0; word(24'h0000FF, 1'b1);
      chk_state("R5 held after k run", k, (k == 0) ? 1 : 0);
    end

    // saturation
    restart(1'b1);
    for (int i = 0; i < 300; i++) begin
      word(24'h000010, 1'b1);
      if (i >= 250) chk_state("R7 saturating count", (i + 1 > 255) ? 255 : i + 1, 0);
    end
    restart(1'b1);
    chk_state("R6 clears after saturation", 0, 1);
    rx_bist = 1'b0; tx_bist = 1'b0;
    word('0, 1'b1);
    finish_run();
  end
endmodule